// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one starting column address into the sequence of column addresses that a memory burst visits, one address per data beat. A small configuration port sets the burst length (2, 4 or 8 beats) and the ordering (wrapping sequential or XOR interleaved). A single-cycle start pulse captures the starting column. The block then presents one address per clock with a valid flag, and marks the first and the final beat.

Only the low log2(length) column bits are reordered, inside the block of columns aligned to the burst length. All higher column bits are copied from the starting address. The length and ordering are sampled when a burst is accepted, so the configuration can be rewritten while a burst is running without changing that burst. The block ignores a start that arrives in the middle of a burst. A start that arrives during the final beat is accepted, so bursts can follow each other back to back.

Top module: `burst_col_seq`

## Requirements
- R1: The length code on `cfg_len_code` selects the burst length: 2'b01 gives 2 beats, 2'b10 gives 4 beats and 2'b11 gives 8 beats. After an accepted start, `beat_valid` is high for exactly that many consecutive cycles, beginning in the cycle after the start edge.
- R2: In sequential mode (`cfg_interleave`=0), the low bits of beat k equal (start low bits + k) modulo the length. For example, length 8 with start 5 gives 5,6,7,0,1,2,3,4, and length 4 with start 3 gives 3,0,1,2.
- R3: In interleaved mode (`cfg_interleave`=1), the low bits of beat k equal (start low bits XOR k). For example, length 8 with start 2 gives 2,3,0,1,6,7,4,5, and length 4 with start 3 gives 3,2,1,0.
- R4: Column bits at and above bit log2(length) equal the starting column on every beat.
- R5: `beat_first` is high only on beat 0, and `beat_last` is high only on the final beat of a burst.
- R6: A start pulse that arrives while a burst is active and is not on its final beat is ignored. A start pulse during the final beat is accepted, and its beat 0 follows in the next cycle.
- R7: The reserved length code 2'b00 runs bursts of 2 beats and sets `cfg_err`. A later write with a valid code clears `cfg_err`.
- R8: The length and ordering are sampled when a start is accepted. A configuration write during a burst takes effect only from the next burst.
- R9: After reset the block is idle with `beat_valid` low, `cfg_err` low, length 2 and sequential ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len_code | input | 2 | Burst length code |
| cfg_interleave | input | 1 | 1 selects interleaved ordering, 0 selects sequential |
| start | input | 1 | Burst start pulse |
| start_col | input | COL_W | Starting column address |
| beat_valid | output | 1 | A column address is presented this cycle |
| beat_col | output | COL_W | Column address for the current beat |
| beat_first | output | 1 | Current beat is the first of the burst |
| beat_last | output | 1 | Current beat is the last of the burst |
| cfg_err | output | 1 | Reserved length code is programmed |

## Verification
The hardest case to reach is a start pulse that lands exactly on the final beat of a burst. The same burst can also have a configuration write arriving in its middle. The driver watches `beat_last` at the falling edge and raises `start` in that cycle. It rewrites the length and ordering a few beats into a running burst, and it pulses `start` in the middle of bursts. The scoreboard queue only gains entries for starts that the requirements say are accepted. Any extra beat therefore appears as a pop from an empty queue, and any missing beat is left behind in the queue.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_len_code,
  input  logic             cfg_interleave,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_first,
  output logic             beat_last,
  output logic             cfg_err
);
  localparam int IDX_W = 3;

  logic [1:0]       len_code_q;
  logic             il_cfg_q;
  logic             err_q;
  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] mask_q;
  logic             il_q;
  logic [COL_W-1:0] base_q;
  logic             accept;
  logic [IDX_W-1:0] seq_low, il_low, low;
  logic [COL_W-1:0] wide_mask, wide_low;

  function automatic logic [IDX_W-1:0] span_mask(input logic [1:0] code);
    case (code)
      2'b10:   span_mask = 3'b011;
      2'b11:   span_mask = 3'b111;
      default: span_mask = 3'b001;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_code_q <= 2'b01;
      il_cfg_q   <= 1'b0;
      err_q      <= 1'b0;
    end else if (cfg_we) begin
      len_code_q <= cfg_len_code;
      il_cfg_q   <= cfg_interleave;
      err_q      <= (cfg_len_code == 2'b00);
    end
  end

  assign beat_last  = active_q && (idx_q == mask_q);
  assign accept     = start && (!active_q || beat_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      mask_q   <= 3'b001;
      il_q     <= 1'b0;
      base_q   <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      mask_q   <= span_mask(len_code_q);
      il_q     <= il_cfg_q;
      base_q   <= start_col;
    end else if (active_q) begin
      if (beat_last) active_q <= 1'b0;
      else           idx_q    <= idx_q + 1'b1;
    end
  end

  assign seq_low    = base_q[IDX_W-1:0] + idx_q;
  assign il_low     = base_q[IDX_W-1:0] ^ idx_q;
  assign low        = il_q ? il_low : seq_low;
  assign wide_mask  = {{(COL_W-IDX_W){1'b0}}, mask_q};
  assign wide_low   = {{(COL_W-IDX_W){1'b0}}, low};
  assign beat_col   = (base_q & ~wide_mask) | (wide_low & wide_mask);
  assign beat_valid = active_q;
  assign beat_first = active_q && (idx_q == '0);
  assign cfg_err    = err_q;

  AST_FIRST_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    beat_first |-> $past(start)) else $error("first without start"); // R5
  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid) else $error("last without valid"); // R5
  AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && !start) |=> !beat_valid) else $error("beat after last"); // R1
  AST_RESTART_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && start) |=> beat_first) else $error("back-to-back lost"); // R6
  AST_MIDBURST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> (beat_valid && !beat_first)) else $error("burst cut"); // R6
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_first) |-> ((beat_col >> 3) == ($past(beat_col) >> 3))) else $error("upper bits moved"); // R4
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_err == ($past(cfg_len_code) == 2'b00))) else $error("err flag"); // R7
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_len_code = 2'b01;
  logic             cfg_interleave = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             beat_valid;
  logic [COL_W-1:0] beat_col;
  logic             beat_first, beat_last, cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int m_len = 2;
  bit m_il = 1'b0;
  logic [COL_W+1:0] expq[$];

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len_code(cfg_len_code),
    .cfg_interleave(cfg_interleave), .start(start), .start_col(start_col),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_first(beat_first),
    .beat_last(beat_last), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input int len,
                                               input bit il, input int k);
    logic [COL_W-1:0] m, lo;
    m  = COL_W'(len - 1);
    lo = il ? ((s & m) ^ COL_W'(k)) : ((s + COL_W'(k)) & m);
    return (s & ~m) | lo;
  endfunction

  task automatic push_burst(input logic [COL_W-1:0] s);
    for (int k = 0; k < m_len; k++)
      expq.push_back({exp_col(s, m_len, m_il, k), k == 0, k == m_len - 1});
  endtask

  task automatic write_cfg(input logic [1:0] code, input bit il);
    @(negedge clk);
    cfg_we = 1'b1; cfg_len_code = code; cfg_interleave = il;
    @(negedge clk);
    cfg_we = 1'b0;
    m_len = (code == 2'b10) ? 4 : (code == 2'b11) ? 8 : 2;
    m_il = il;
  endtask

  task automatic fire(input logic [COL_W-1:0] s);
    @(negedge clk);
    start = 1'b1; start_col = s;
    push_burst(s);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
    check(!beat_valid, "R1 idle after burst", beat_valid, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && beat_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected beat", beat_col, 0);
      end else begin
        logic [COL_W+1:0] e;
        e = expq.pop_front();
        check({beat_col, beat_first, beat_last} == e, "R1 R2 R3 R4 R5 beat", {beat_col, beat_first, beat_last}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!beat_valid && !cfg_err, "R9 reset state", {beat_valid, cfg_err}, 0);
    fire(11'h5A6); drain();                              // R9 default length 2 sequential

    write_cfg(2'b11, 1'b0); fire(11'h2AD); drain();      // R2 len8 start5
    write_cfg(2'b11, 1'b1); fire(11'h7F2); drain();      // R3 len8 start2
    write_cfg(2'b10, 1'b0); fire(11'h00B); drain();      // R2 len4 start3
    write_cfg(2'b10, 1'b1); fire(11'h3C7); drain();      // R3 len4 start3, R4 upper bits
    write_cfg(2'b01, 1'b1); fire(11'h401); drain();      // R1 len2 interleaved
    check(!cfg_err, "R7 err low on valid code", cfg_err, 0);

    write_cfg(2'b00, 1'b0);                              // R7 reserved
    check(cfg_err, "R7 err high", cfg_err, 1);
    fire(11'h1F7); drain();
    write_cfg(2'b10, 1'b0);
    check(!cfg_err, "R7 err cleared", cfg_err, 0);

    write_cfg(2'b11, 1'b0);                              // R6 mid-burst start ignored
    fire(11'h0E4);
    @(negedge clk); start = 1'b1; start_col = 11'h123;
    @(negedge clk); start = 1'b0;
    drain();

    fire(11'h016);                                       // R6 back-to-back on last beat
    while (!beat_last) @(negedge clk);
    start = 1'b1; start_col = 11'h6A9;
    push_burst(11'h6A9);
    @(negedge clk); start = 1'b0;
    drain();

    write_cfg(2'b10, 1'b1);                              // R8 config write mid-burst
    fire(11'h235);
    @(negedge clk); cfg_we = 1'b1; cfg_len_code = 2'b11; cfg_interleave = 1'b0;
    @(negedge clk); cfg_we = 1'b0;
    m_len = 8; m_il = 1'b0;
    drain();
    fire(11'h235); drain();                              // R8 new config applies

    check(expq.size() == 0, "R1 queue empty", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule